// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is a purely combinational 64-bit rotate-and-mask datapath that serves every rotate and shift form of an integer execution stage. One shared left rotator, built from three cascaded 4:1 multiplexer stages, produces a rotated copy of the source word. Two bound-driven mask generators each produce a one-sided mask. Their combination selects which rotated bits survive. Bits outside the mask come from an insert target word, from sign fill, or are zero.

An operation class selects among rotate with both ends cleared, rotate keeping the low end, rotate keeping the high end, shift left and shift right. Three flags refine the class: a word flag for 32-bit forms, a signed flag for arithmetic right shifts and for the extend-then-shift-left form, and a merge flag for insert-under-mask. Right shifts are performed as left rotations by the negated amount. A carry output reports when a negative value loses 1-bits in an arithmetic right shift. Bit positions are numbered from the least significant bit (bit 0) upward throughout.

Top module: `rotmask_unit`

## Requirements
- R1: With op_sel = 0 (rotate, both ends cleared), word_mode = 0 and mask_lo <= mask_hi, result equals src_word rotated left by shamt[5:0], ANDed with ones at bit positions mask_lo through mask_hi inclusive; shamt[6] is ignored for rotations.
- R2: With op_sel = 0 and mask_lo > mask_hi, the mask wraps: it holds ones at every position >= mask_lo and every position <= mask_hi.
- R3: op_sel = 1 (keep low end) uses ones at positions 0 through mask_hi; op_sel = 2 (keep high end) uses ones at positions mask_lo through 63.
- R4: For rotate classes with word_mode = 1, the low 32 bits of src_word are copied into both halves and rotated left by shamt[4:0], so the rotated word appears in both halves before masking.
- R5: With merge_en = 1 on a rotate class, bits outside the mask are taken from ins_word; merge_en has no effect on op_sel = 3 or 4.
- R6: op_sel = 3 (shift left, signed_mode = 0): in 64-bit form the amount is shamt[6:0] and an amount of 64 or more gives zero; in word form the amount is shamt[5:0], the low 32 bits are shifted, the upper 32 result bits are zero and an amount of 32 or more gives zero.
- R7: op_sel = 4 with signed_mode = 0 is a logical right shift of src_word (64-bit, amount shamt[6:0]) or of its low 32 bits zero-extended (word, amount shamt[5:0]); an amount at or above the width gives zero.
- R8: op_sel = 4 with signed_mode = 1 is an arithmetic right shift; the sign is bit 63 (64-bit) or bit 31 (word), every vacated position and all upper 32 bits in word form take the sign, and an amount at or above the width gives all sign bits.
- R9: carry_out is 1 only for op_sel = 4 with signed_mode = 1, a negative source (per R8's sign) and at least one 1-bit among the bits shifted out; otherwise 0.
- R10: op_sel = 3 with signed_mode = 1 and word_mode = 0 sign-extends the low 32 bits of src_word to 64 bits, then shifts left by shamt[6:0] (64 or more gives zero).
- R11: op_sel values 5, 6 and 7 give result = 0 and carry_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 64 | Value to rotate or shift |
| ins_word | input | 64 | Insert target supplying unmasked bits when merging |
| shamt | input | 7 | Rotate or shift amount |
| mask_lo | input | 6 | Lower mask bound (LSB numbering) |
| mask_hi | input | 6 | Upper mask bound (LSB numbering) |
| op_sel | input | 3 | Operation class: 0 rotate both, 1 keep low, 2 keep high, 3 shift left, 4 shift right |
| word_mode | input | 1 | Select 32-bit form |
| signed_mode | input | 1 | Arithmetic right shift, or extend-then-shift-left |
| merge_en | input | 1 | Insert-under-mask for rotate classes |
| result | output | 64 | Rotated, masked and filled result |
| carry_out | output | 1 | Lost 1-bits of a negative arithmetic right shift |

## Verification
The embedded assertions watch properties that hold for any input on every evaluation: a shift left leaves the low bits below the amount clear, an oversized logical right shift returns zero, an equal-bound rotate mask is a single bit, carry only appears alongside a negative result, undefined classes return zero, and a half-replicated word stays half-replicated through the rotator. The exact bit values, the mask wrap, the insert merge, the sign-extension path and the carry on chosen inputs are shown only by the bench's scenarios against its bit-loop reference model.

// File: rtl/rm_pkg.sv
package rm_pkg;
    typedef enum logic [2:0] {
        RM_ROT_BOTH      = 3'd0,
        RM_ROT_KEEP_LOW  = 3'd1,
        RM_ROT_KEEP_HIGH = 3'd2,
        RM_SHL           = 3'd3,
        RM_SHR           = 3'd4
    } rm_op_e;
endpackage

// File: rtl/rm_rot_stage.sv
// One 4:1 stage of the left rotator: rotates by sel * STEP.
module rm_rot_stage #(
    parameter int DATA_W = 64,
    parameter int STEP   = 1
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] opt [4];

    for (genvar j = 0; j < 4; j++) begin : g_opt
        logic [2*DATA_W-1:0] wide;
        assign wide   = {din, din} << (j * STEP);
        assign opt[j] = wide[2*DATA_W-1:DATA_W];
    end

    assign dout = opt[sel];
endmodule

// File: rtl/rm_rotator.sv
// Cascaded radix-4 left rotator.
module rm_rotator #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int NST   = (AMT_W + 1) / 2,
    localparam int HALF  = DATA_W / 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0]  stg [NST+1];
    logic [2*NST-1:0]   amt_x;

    assign amt_x  = (2*NST)'(amt);
    assign stg[0] = din;

    for (genvar g = 0; g < NST; g++) begin : g_stage
        rm_rot_stage #(.DATA_W(DATA_W), .STEP(4 ** g)) u_stage (
            .din (stg[g]),
            .sel (amt_x[2*g+1:2*g]),
            .dout(stg[g+1])
        );
    end

    assign dout = stg[NST];

    // R4: a half-periodic input stays half-periodic after any rotation
    always_comb begin
        if (din[DATA_W-1:HALF] == din[HALF-1:0])
            a_r4_word_halves: assert (dout[DATA_W-1:HALF] == dout[HALF-1:0])
                else $error("rotator broke half replication");
    end
endmodule

// File: rtl/rm_maskgen.sv
// One-sided mask: ones at positions >= bound (FROM_LOW=0) or <= bound (FROM_LOW=1).
module rm_maskgen #(
    parameter int DATA_W   = 64,
    parameter bit FROM_LOW = 1'b0,
    localparam int AMT_W   = $clog2(DATA_W)
) (
    input  logic              en,
    input  logic [AMT_W-1:0]  bound,
    output logic [DATA_W-1:0] mask
);
    localparam logic [AMT_W-1:0] TOP_BIT = AMT_W'(DATA_W - 1);

    if (FROM_LOW) begin : g_le
        assign mask = en ? ({DATA_W{1'b1}} >> (TOP_BIT - bound)) : '0;
    end else begin : g_ge
        assign mask = en ? ({DATA_W{1'b1}} << bound) : '0;
    end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rm_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_word,
    input  logic [DATA_W-1:0] ins_word,
    input  logic [AMT_W:0]    shamt,
    input  logic [AMT_W-1:0]  mask_lo,
    input  logic [AMT_W-1:0]  mask_hi,
    input  logic [2:0]        op_sel,
    input  logic              word_mode,
    input  logic              signed_mode,
    input  logic              merge_en,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int HALF = DATA_W / 2;
    localparam logic [AMT_W-1:0] TOP_BIT  = AMT_W'(DATA_W - 1);
    localparam logic [AMT_W-1:0] HALF_TOP = AMT_W'(HALF - 1);

    rm_op_e            op;
    logic              is_rot, over, sra, sign_bit;
    logic [AMT_W-1:0]  n_eff, rot_amt, lo_b, hi_b;
    logic              lo_en, hi_en, wrap;
    logic [DATA_W-1:0] rot_in, rot_out, m_ge, m_le, mask;
    logic [DATA_W-1:0] fill, keep, lost_mask;

    // Control: operand select, rotate amount and mask bounds
    always_comb begin
        op       = rm_op_e'(op_sel);
        is_rot   = (op == RM_ROT_BOTH) || (op == RM_ROT_KEEP_LOW) || (op == RM_ROT_KEEP_HIGH);
        over     = word_mode ? shamt[AMT_W-1] : shamt[AMT_W];
        n_eff    = word_mode ? {1'b0, shamt[AMT_W-2:0]} : shamt[AMT_W-1:0];
        if (word_mode)
            rot_in = {src_word[HALF-1:0], src_word[HALF-1:0]};
        else if (op == RM_SHL && signed_mode)
            rot_in = {{HALF{src_word[HALF-1]}}, src_word[HALF-1:0]};
        else
            rot_in = src_word;
        rot_amt  = (op == RM_SHR) ? (AMT_W'(0) - n_eff) : n_eff;
        lo_b  = '0;
        hi_b  = TOP_BIT;
        lo_en = 1'b0;
        hi_en = 1'b0;
        wrap  = 1'b0;
        case (op)
            RM_ROT_BOTH: begin
                lo_b  = mask_lo;
                hi_b  = mask_hi;
                lo_en = 1'b1;
                hi_en = 1'b1;
                wrap  = mask_lo > mask_hi;
            end
            RM_ROT_KEEP_LOW: begin
                hi_b  = mask_hi;
                lo_en = 1'b1;
                hi_en = 1'b1;
            end
            RM_ROT_KEEP_HIGH: begin
                lo_b  = mask_lo;
                lo_en = 1'b1;
                hi_en = 1'b1;
            end
            RM_SHL: begin
                lo_b  = n_eff;
                hi_b  = word_mode ? HALF_TOP : TOP_BIT;
                lo_en = !over;
                hi_en = !over;
            end
            RM_SHR: begin
                hi_b  = (word_mode ? HALF_TOP : TOP_BIT) - n_eff;
                lo_en = !over;
                hi_en = !over;
            end
            default: ;
        endcase
    end

    rm_rotator #(.DATA_W(DATA_W)) u_rot (
        .din (rot_in),
        .amt (rot_amt),
        .dout(rot_out)
    );

    rm_maskgen #(.DATA_W(DATA_W), .FROM_LOW(1'b0)) u_mask_ge (
        .en   (lo_en),
        .bound(lo_b),
        .mask (m_ge)
    );

    rm_maskgen #(.DATA_W(DATA_W), .FROM_LOW(1'b1)) u_mask_le (
        .en   (hi_en),
        .bound(hi_b),
        .mask (m_le)
    );

    // Output: masked merge, sign fill and carry
    always_comb begin
        mask      = wrap ? (m_ge | m_le) : (m_ge & m_le);
        sign_bit  = word_mode ? src_word[HALF-1] : src_word[DATA_W-1];
        sra       = (op == RM_SHR) && signed_mode;
        fill      = (sra && sign_bit) ? ~mask : '0;
        keep      = (is_rot && merge_en) ? (ins_word & ~mask) : '0;
        result    = (rot_out & mask) | keep | fill;
        if (over)
            lost_mask = word_mode ? {{HALF{1'b0}}, {HALF{1'b1}}} : {DATA_W{1'b1}};
        else
            lost_mask = (DATA_W'(1) << n_eff) - DATA_W'(1);
        carry_out = sra && sign_bit && (|(src_word & lost_mask));
    end

    always_comb begin
        if (op == RM_SHL && !over)
            a_r6_shl_low_clear: assert ((result & ((DATA_W'(1) << n_eff) - DATA_W'(1))) == '0)
                else $error("shift left left low bits set");
        if (op == RM_SHR && !signed_mode && over)
            a_r7_lsr_over_zero: assert (result == '0)
                else $error("oversized logical right shift not zero");
        if (op == RM_ROT_BOTH && mask_lo == mask_hi)
            a_r2_single_bit_mask: assert ($countones(mask) == 1)
                else $error("equal bounds did not give one mask bit");
        if (carry_out)
            a_r9_carry_neg_result: assert (result[DATA_W-1])
                else $error("carry without negative result");
        if (op_sel > 3'd4)
            a_r11_undef_zero: assert (result == '0 && !carry_out)
                else $error("undefined class produced output");
    end
endmodule

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [63:0] src_word, ins_word, result;
    logic [6:0]  shamt;
    logic [5:0]  mask_lo, mask_hi;
    logic [2:0]  op_sel;
    logic        word_mode, signed_mode, merge_en, carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        cy;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    rotmask_unit u_dut (
        .src_word(src_word), .ins_word(ins_word), .shamt(shamt),
        .mask_lo(mask_lo), .mask_hi(mask_hi), .op_sel(op_sel),
        .word_mode(word_mode), .signed_mode(signed_mode), .merge_en(merge_en),
        .result(result), .carry_out(carry_out)
    );

    // Bit-loop reference model built from the requirements
    function automatic logic [64:0] ref_model(
        input logic [63:0] s, input logic [63:0] ins, input logic [6:0] sh,
        input logic [5:0] lo, input logic [5:0] hi, input logic [2:0] op,
        input logic w, input logic sg, input logic mg);
        logic [63:0] d, r, m, res;
        logic cy, sb;
        int n, lim;
        res = '0; cy = 1'b0; r = '0; m = '0;
        if (op <= 3'd2) begin
            d = w ? {s[31:0], s[31:0]} : s;
            n = w ? int'(sh[4:0]) : int'(sh[5:0]);
            for (int i = 0; i < 64; i++) r[(i + n) % 64] = d[i];
            for (int i = 0; i < 64; i++) begin
                if (op == 3'd0)
                    m[i] = (lo <= hi) ? (i >= lo && i <= hi) : (i >= lo || i <= hi);
                else if (op == 3'd1)
                    m[i] = (i <= hi);
                else
                    m[i] = (i >= lo);
            end
            res = (r & m) | (mg ? (ins & ~m) : 64'd0);
        end else if (op == 3'd3) begin
            if (sg && !w) begin
                d = {{32{s[31]}}, s[31:0]}; lim = 64; n = int'(sh);
            end else if (w) begin
                d = {32'd0, s[31:0]}; lim = 32; n = int'(sh[5:0]);
            end else begin
                d = s; lim = 64; n = int'(sh);
            end
            for (int i = 0; i < 64; i++)
                res[i] = (i >= n && i < lim) ? d[i - n] : 1'b0;
        end else if (op == 3'd4) begin
            lim = w ? 32 : 64;
            n   = w ? int'(sh[5:0]) : int'(sh);
            sb  = sg & s[lim - 1];
            for (int i = 0; i < 64; i++)
                res[i] = (i < lim && i + n < lim) ? s[i + n] : sb;
            for (int j = 0; j < lim; j++)
                if (j < n && s[j] && sb) cy = 1'b1;
        end
        return {cy, res};
    endfunction

    task automatic apply(input logic [63:0] s, input logic [63:0] ins, input logic [6:0] sh,
                         input logic [5:0] lo, input logic [5:0] hi, input logic [2:0] op,
                         input logic w, input logic sg, input logic mg, input string tag);
        logic [64:0] e;
        exp_t item;
        @(posedge clk);
        src_word = s; ins_word = ins; shamt = sh; mask_lo = lo; mask_hi = hi;
        op_sel = op; word_mode = w; signed_mode = sg; merge_en = mg;
        e = ref_model(s, ins, sh, lo, hi, op, w, sg, mg);
        item.res = e[63:0];
        item.cy  = e[64];
        item.tag = tag;
        sb_q.push_back(item);
    endtask

    // Monitor: compare away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || carry_out !== e.cy) begin
                errors++;
                $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                         e.tag, result, carry_out, e.res, e.cy);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    localparam logic [63:0] PAT  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] NEG  = 64'hF000_0000_0000_00F1;
    localparam logic [63:0] INSW = 64'hAAAA_5555_AAAA_5555;

    initial begin
        src_word = '0; ins_word = '0; shamt = '0; mask_lo = '0; mask_hi = '0;
        op_sel = '0; word_mode = 0; signed_mode = 0; merge_en = 0;
        apply(64'd0, 64'd0, 7'd0, 6'd0, 6'd0, 3'd0, 0, 0, 0, "R1 idle zero inputs");
        // R1: plain rotates, shamt[6] ignored
        apply(PAT, 64'd0, 7'd8,  6'd0, 6'd63, 3'd0, 0, 0, 0, "R1 rotate by 8 full mask");
        apply(PAT, 64'd0, 7'h48, 6'd0, 6'd63, 3'd0, 0, 0, 0, "R1 rotate shamt bit6 ignored");
        apply(PAT, 64'd0, 7'd20, 6'd16, 6'd40, 3'd0, 0, 0, 0, "R1 rotate inner mask");
        // R2: wrapped and single-bit masks
        apply(PAT, 64'd0, 7'd4, 6'd60, 6'd3, 3'd0, 0, 0, 0, "R2 wrap mask");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 7'd0, 6'd17, 6'd17, 3'd0, 0, 0, 0, "R2 single bit");
        // R3
        apply(PAT, 64'd0, 7'd12, 6'd0, 6'd15, 3'd1, 0, 0, 0, "R3 keep low end");
        apply(PAT, 64'd0, 7'd12, 6'd48, 6'd0, 3'd2, 0, 0, 0, "R3 keep high end");
        // R4
        apply(64'hFFFF_0000_1234_5678, 64'd0, 7'd4, 6'd0, 6'd63, 3'd0, 1, 0, 0, "R4 word rotate both halves");
        apply(64'h0000_0000_8000_0001, 64'd0, 7'd35, 6'd0, 6'd31, 3'd1, 1, 0, 0, "R4 word rotate uses shamt[4:0]");
        // R5
        apply(PAT, INSW, 7'd8, 6'd8, 6'd15, 3'd0, 0, 0, 1, "R5 insert under mask");
        apply(PAT, INSW, 7'd0, 6'd40, 6'd20, 3'd2, 0, 0, 1, "R5 insert keep high");
        apply(PAT, INSW, 7'd4, 6'd0, 6'd0, 3'd3, 0, 0, 1, "R5 merge ignored on shift left");
        apply(PAT, INSW, 7'd4, 6'd0, 6'd0, 3'd4, 0, 0, 1, "R5 merge ignored on shift right");
        // R6
        apply(PAT, 64'd0, 7'd4,  6'd0, 6'd0, 3'd3, 0, 0, 0, "R6 shl 4");
        apply(PAT, 64'd0, 7'd63, 6'd0, 6'd0, 3'd3, 0, 0, 0, "R6 shl 63");
        apply(PAT, 64'd0, 7'd64, 6'd0, 6'd0, 3'd3, 0, 0, 0, "R6 shl 64 zero");
        apply(PAT, 64'd0, 7'd8,  6'd0, 6'd0, 3'd3, 1, 0, 0, "R6 word shl 8");
        apply(PAT, 64'd0, 7'd31, 6'd0, 6'd0, 3'd3, 1, 0, 0, "R6 word shl 31");
        apply(PAT, 64'd0, 7'd32, 6'd0, 6'd0, 3'd3, 1, 0, 0, "R6 word shl 32 zero");
        apply(PAT, 64'd0, 7'd72, 6'd0, 6'd0, 3'd3, 1, 0, 0, "R6 word shl ignores bit6");
        // R7
        apply(NEG, 64'd0, 7'd4,  6'd0, 6'd0, 3'd4, 0, 0, 0, "R7 lsr 4");
        apply(NEG, 64'd0, 7'd64, 6'd0, 6'd0, 3'd4, 0, 0, 0, "R7 lsr 64 zero");
        apply(64'hFFFF_FFFF_8000_0010, 64'd0, 7'd1, 6'd0, 6'd0, 3'd4, 1, 0, 0, "R7 word lsr 1");
        apply(64'hFFFF_FFFF_8000_0010, 64'd0, 7'd32, 6'd0, 6'd0, 3'd4, 1, 0, 0, "R7 word lsr 32 zero");
        // R8, R9
        apply(NEG, 64'd0, 7'd4,  6'd0, 6'd0, 3'd4, 0, 1, 0, "R8 R9 sra negative lost ones");
        apply(NEG, 64'd0, 7'd70, 6'd0, 6'd0, 3'd4, 0, 1, 0, "R8 R9 sra oversized");
        apply(64'h8000_0000_0000_0000, 64'd0, 7'd8, 6'd0, 6'd0, 3'd4, 0, 1, 0, "R9 sra negative no lost ones");
        apply(64'h7000_0000_0000_00FF, 64'd0, 7'd4, 6'd0, 6'd0, 3'd4, 0, 1, 0, "R9 sra positive no carry");
        apply(64'h0000_0000_8000_0003, 64'd0, 7'd4, 6'd0, 6'd0, 3'd4, 1, 1, 0, "R8 R9 word sra negative");
        apply(64'h0000_0000_8000_0000, 64'd0, 7'd33, 6'd0, 6'd0, 3'd4, 1, 1, 0, "R8 word sra oversized");
        apply(64'hFFFF_FFFF_4000_0001, 64'd0, 7'd4, 6'd0, 6'd0, 3'd4, 1, 1, 0, "R8 word sra positive");
        // R10
        apply(64'h1234_5678_8000_0001, 64'd0, 7'd4,  6'd0, 6'd0, 3'd3, 0, 1, 0, "R10 extend then shl");
        apply(64'h1234_5678_7000_0001, 64'd0, 7'd40, 6'd0, 6'd0, 3'd3, 0, 1, 0, "R10 extend positive shl 40");
        apply(64'h1234_5678_8000_0001, 64'd0, 7'd64, 6'd0, 6'd0, 3'd3, 0, 1, 0, "R10 extend shl 64 zero");
        // R11
        apply(NEG, INSW, 7'd4, 6'd0, 6'd63, 3'd5, 0, 1, 1, "R11 class 5 zero");
        apply(NEG, INSW, 7'd4, 6'd0, 6'd63, 3'd6, 1, 1, 1, "R11 class 6 zero");
        apply(NEG, INSW, 7'd4, 6'd0, 6'd63, 3'd7, 0, 0, 1, "R11 class 7 zero");
        // Mixed patterns
        for (int k = 0; k < 60; k++) begin
            logic [2:0] op;
            string tag;
            op = 3'($urandom_range(0, 4));
            case (op)
                3'd0: tag = "R1/R2 random rotate";
                3'd1, 3'd2: tag = "R3 random rotate";
                3'd3: tag = "R6/R10 random shl";
                default: tag = "R7/R8/R9 random shr";
            endcase
            apply({$urandom, $urandom}, {$urandom, $urandom}, 7'($urandom), 6'($urandom),
                  6'($urandom), op, 1'($urandom), 1'($urandom), 1'($urandom), tag);
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule